// File: doc/BRIEF.md
# Triggered Memory-to-Memory Transfer Channel

This block is one transfer channel that copies data units, either single bytes or 16-bit words, from a source address to a destination address. It uses a simple synchronous memory port: the read data returns one cycle after the read strobe, and the channel then issues the matching write. Software arms the channel. Arming loads the configured source and destination addresses into working pointers. Each pointer then steps up, steps down or holds after every unit, and each pointer is set independently. Transfers start on a trigger. The trigger is either the one hardware line picked by a select field or a software request bit.

Four modes set how triggers map to data movement. In the unit-per-trigger modes, each trigger moves one unit. In the block-per-trigger modes, one trigger moves the whole count back to back. Either kind can disarm at completion or rearm by itself, and rearming reloads the pointers. A variable-length option treats the first unit moved as a length value. The channel then moves that length plus a code-dependent offset, capped at the configured count. Completion raises a sticky interrupt flag.

Top module: `dma_chan`

## Requirements
- R1: `cfg_word`=1 moves 16-bit units and steps pointers by 2. `cfg_word`=0 moves bytes, steps by 1, and drives the upper half of `mem_wr_data` as zero.
- R2: With `cfg_mode`=00 (one unit per trigger, disarm), each trigger moves one unit. After `cfg_count` units, `irq` sets and `armed` clears.
- R3: With `cfg_mode`=01 (block per trigger, disarm), one trigger moves `cfg_count` units with a read every second cycle. `irq` rises 2×`cfg_count` clock edges after the accepting edge, and the channel disarms.
- R4: `cfg_mode`=10 and 11 act like 00 and 01, except that at completion the channel stays armed and the pointers reload from `cfg_src`/`cfg_dst`, so a second round repeats the same addresses.
- R5: Only `trig_in[cfg_tsel]` triggers the channel. A `sw_req` pulse while armed also triggers it and is remembered until accepted. Each accepted trigger is consumed once, so one `sw_req` pulse moves exactly one unit in mode 00.
- R6: Triggers and `sw_req` pulses that arrive while the channel is disarmed are dropped and cause no transfer later.
- R7: An `arm` pulse while disarmed copies `cfg_src` and `cfg_dst` into the working pointers. The first unit is read from `cfg_src` and written to `cfg_dst`.
- R8: Step codes, applied per pointer independently, are: 00 or 11 hold, 01 add the unit size, 10 subtract the unit size.
- R9: With `cfg_vlen` from 1 to 4, the first unit read is a length L. The total number of units moved, including that first one, is min(max(L+k,1), `cfg_count`), where k is 1, 0, 2 or 3 for codes 1, 2, 3 and 4. Other codes use `cfg_count`.
- R10: With `cfg_count`=0, triggers start no transfer, `irq` stays low and the channel stays armed.
- R11: `irq` holds until an `irq_clr` pulse. A completion in the same cycle as `irq_clr` wins.
- R12: A write is issued with the data returned for its read. The read strobe is never high in two consecutive cycles.
- R13: A `disarm` pulse clears `armed`, and no read is issued while disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Units per completion (cap in variable-length use) |
| cfg_mode | input | 2 | Bit0 block per trigger, bit1 auto-rearm |
| cfg_word | input | 1 | 1 = 16-bit units, 0 = bytes |
| cfg_src_step | input | 2 | Source pointer step code |
| cfg_dst_step | input | 2 | Destination pointer step code |
| cfg_vlen | input | 3 | Variable-length code |
| cfg_tsel | input | TSEL_W | Hardware trigger select |
| trig_in | input | NTRIG | Hardware trigger pulses |
| sw_req | input | 1 | Software trigger pulse |
| arm | input | 1 | Arm pulse |
| disarm | input | 1 | Disarm pulse |
| irq_clr | input | 1 | Clears the completion flag |
| armed | output | 1 | Channel armed |
| irq | output | 1 | Sticky completion flag |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 16 | Write data |
| mem_wr_word | output | 1 | Write covers two bytes |

## Verification
The assertions assume that software holds every `cfg_*` input steady from the `arm` pulse until the channel is disarmed. They also assume that the memory returns read data exactly one cycle after the strobe. The bench changes configuration only while the channel is disarmed, and its memory model answers with a fixed one-cycle latency. The sweep places the source region below the destination region, so reads never see the channel's own writes. It also treats trigger lines as single-cycle pulses.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int UNIT_W = 16;

  localparam logic [1:0] STEP_HOLD = 2'b00;
  localparam logic [1:0] STEP_INC  = 2'b01;
  localparam logic [1:0] STEP_DEC  = 2'b10;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } ch_state_t;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr import dma_chan_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              word,
  input  logic [1:0]        step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] amt;
  assign amt = word ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    case (step)
      STEP_INC: nxt = ptr + amt;
      STEP_DEC: nxt = ptr - amt;
      default:  nxt = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= base;
    else if (adv)  ptr <= nxt;
  end

  // R8
  ptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && step == STEP_INC) |=>
      ptr == $past(ptr) + ($past(word) ? ADDR_W'(2) : ADDR_W'(1)));

  // R8
  ptr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && step == STEP_DEC) |=>
      ptr == $past(ptr) - ($past(word) ? ADDR_W'(2) : ADDR_W'(1)));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && (step == STEP_HOLD || step == 2'b11)) |=> $stable(ptr));

  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(base));
endmodule

// File: rtl/dma_trig.sv
module dma_trig #(
  parameter int NTRIG  = 8,
  parameter int TSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTRIG-1:0]  lines,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sw_req,
  input  logic              armed,
  input  logic              accept,
  output logic              hit,
  output logic              sw_pend
);
  logic hw;
  assign hw  = (int'(tsel) < NTRIG) ? lines[tsel] : 1'b0;
  assign hit = armed && (hw || sw_req || sw_pend);

  always_ff @(posedge clk) begin
    if (rst)                  sw_pend <= 1'b0;
    else if (!armed || accept) sw_pend <= 1'b0;
    else if (sw_req)          sw_pend <= 1'b1;
  end

  // R6
  sw_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !sw_pend);

  // R5
  sw_consume_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !sw_pend);
endmodule

// File: rtl/dma_len.sv
module dma_len #(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       code,
  input  logic [15:0]      first,
  input  logic             word,
  input  logic [CNT_W-1:0] count,
  output logic             var_on,
  output logic [CNT_W-1:0] limit
);
  localparam int SUM_W = ((CNT_W > 16) ? CNT_W : 16) + 2;

  logic [15:0]      len_val;
  logic [1:0]       off;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_min1;

  assign len_val = word ? first : {8'h00, first[7:0]};

  always_comb begin
    var_on = 1'b1;
    case (code)
      3'd1:    off = 2'd1;
      3'd2:    off = 2'd0;
      3'd3:    off = 2'd2;
      3'd4:    off = 2'd3;
      default: begin off = 2'd0; var_on = 1'b0; end
    endcase
    sum      = SUM_W'(len_val) + SUM_W'(off);
    sum_min1 = (sum == '0) ? SUM_W'(1) : sum;
    if (!var_on || sum_min1 > SUM_W'(count)) limit = count;
    else                                      limit = sum_min1[CNT_W-1:0];
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan import dma_chan_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int NTRIG  = 8,
  localparam int TSEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_word,
  input  logic [1:0]        cfg_src_step,
  input  logic [1:0]        cfg_dst_step,
  input  logic [2:0]        cfg_vlen,
  input  logic [TSEL_W-1:0] cfg_tsel,
  input  logic [NTRIG-1:0]  trig_in,
  input  logic              sw_req,
  input  logic              arm,
  input  logic              disarm,
  input  logic              irq_clr,
  output logic              armed,
  output logic              irq,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [UNIT_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [UNIT_W-1:0] mem_wr_data,
  output logic              mem_wr_word
);
  ch_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q, limit_q, cnt_inc, eff_lim, len_lim;
  logic              var_on, hit, sw_pend, accept, arm_take, in_wr, fin, ptr_load;
  logic [ADDR_W-1:0] src_ptr, src_nxt, dst_ptr, dst_nxt;

  assign armed    = (state_q != ST_OFF);
  assign accept   = (state_q == ST_WAIT) && hit && (cfg_count != '0) && !disarm;
  assign arm_take = (state_q == ST_OFF) && arm && !disarm;
  assign in_wr    = (state_q == ST_WR);
  assign eff_lim  = (cnt_q == '0 && var_on) ? len_lim : limit_q;
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign fin      = in_wr && !disarm && (cnt_inc >= eff_lim);
  assign ptr_load = arm_take || (fin && cfg_mode[1]);

  dma_trig #(.NTRIG(NTRIG), .TSEL_W(TSEL_W)) trig_i (
    .clk(clk), .rst(rst), .lines(trig_in), .tsel(cfg_tsel), .sw_req(sw_req),
    .armed(armed), .accept(accept), .hit(hit), .sw_pend(sw_pend)
  );

  dma_len #(.CNT_W(CNT_W)) len_i (
    .code(cfg_vlen), .first(mem_rd_data), .word(cfg_word), .count(cfg_count),
    .var_on(var_on), .limit(len_lim)
  );

  dma_ptr #(.ADDR_W(ADDR_W)) src_i (
    .clk(clk), .rst(rst), .load(ptr_load), .adv(in_wr), .word(cfg_word),
    .step(cfg_src_step), .base(cfg_src), .ptr(src_ptr), .nxt(src_nxt)
  );

  dma_ptr #(.ADDR_W(ADDR_W)) dst_i (
    .clk(clk), .rst(rst), .load(ptr_load), .adv(in_wr), .word(cfg_word),
    .step(cfg_dst_step), .base(cfg_dst), .ptr(dst_ptr), .nxt(dst_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      cnt_q       <= '0;
      limit_q     <= '0;
      irq         <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      mem_wr_word <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      if (fin)     irq <= 1'b1;
      if (disarm) begin
        state_q <= ST_OFF;
      end else begin
        case (state_q)
          ST_OFF: if (arm) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            limit_q <= cfg_count;
          end
          ST_WAIT: if (accept) begin
            state_q     <= ST_RD;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= src_ptr;
          end
          ST_RD: state_q <= ST_WR;
          ST_WR: begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= dst_ptr;
            mem_wr_data <= cfg_word ? mem_rd_data : {8'h00, mem_rd_data[7:0]};
            mem_wr_word <= cfg_word;
            if (fin) begin
              cnt_q   <= '0;
              limit_q <= cfg_count;
              state_q <= cfg_mode[1] ? ST_WAIT : ST_OFF;
            end else begin
              cnt_q   <= cnt_inc;
              limit_q <= eff_lim;
              if (cfg_mode[0]) begin
                state_q     <= ST_RD;
                mem_rd_en   <= 1'b1;
                mem_rd_addr <= src_nxt;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: state_q <= ST_OFF;
        endcase
      end
    end
  end

  // R13
  rd_off_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !mem_rd_en);

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> mem_wr_en);

  // R12
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R2
  single_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode[0] && mem_wr_en) |-> !mem_rd_en);

  // R10
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && cfg_count == '0) |=> !mem_rd_en);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

// File: tb/dma_chan_tb_top.sv
module dma_chan_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int NT = 8;
  localparam int SB = 'h40;
  localparam int DB = 'hC0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [CW-1:0] cfg_count;
  logic [1:0]    cfg_mode, cfg_src_step, cfg_dst_step;
  logic          cfg_word;
  logic [2:0]    cfg_vlen, cfg_tsel;
  logic [NT-1:0] trig_in;
  logic          sw_req, arm, disarm, irq_clr;
  logic          armed, irq, mem_rd_en, mem_wr_en, mem_wr_word;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [15:0]   mem_rd_data, mem_wr_data;

  dma_chan #(.ADDR_W(AW), .CNT_W(CW), .NTRIG(NT)) dut_i (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_word(cfg_word),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_vlen(cfg_vlen), .cfg_tsel(cfg_tsel), .trig_in(trig_in),
    .sw_req(sw_req), .arm(arm), .disarm(disarm), .irq_clr(irq_clr),
    .armed(armed), .irq(irq), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_word(mem_wr_word)
  );

  logic [7:0] mem [256];

  always @(posedge clk) begin
    if (mem_rd_en)
      mem_rd_data <= {mem[mem_rd_addr[7:0] + 8'd1], mem[mem_rd_addr[7:0]]};
    if (mem_wr_en) begin
      mem[mem_wr_addr[7:0]] <= mem_wr_data[7:0];
      if (mem_wr_word) mem[mem_wr_addr[7:0] + 8'd1] <= mem_wr_data[15:8];
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic init_mem();
    for (int a = 0; a < 256; a++)
      mem[a] = (a < 128) ? 8'(((a * 7 + 3) | 1)) : 8'h00;
  endtask

  task automatic clear_dst();
    for (int a = 128; a < 256; a++) mem[a] = 8'h00;
  endtask

  task automatic pulse_trig(input bit sw, input int line);
    if (sw) sw_req = 1'b1; else trig_in[line] = 1'b1;
    tick(1);
    sw_req  = 1'b0;
    trig_in = '0;
  endtask

  task automatic pulse_arm();    arm = 1'b1;     tick(1); arm = 1'b0;     endtask
  task automatic pulse_disarm(); disarm = 1'b1;  tick(1); disarm = 1'b0;  endtask
  task automatic pulse_clr();    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; endtask

  task automatic set_cfg(input int mode, input int word, input int ss, input int ds,
                         input int n, input int vlen);
    cfg_src = AW'(SB); cfg_dst = AW'(DB);
    cfg_mode = 2'(mode); cfg_word = 1'(word);
    cfg_src_step = 2'(ss); cfg_dst_step = 2'(ds);
    cfg_count = CW'(n); cfg_vlen = 3'(vlen); cfg_tsel = 3'd2;
  endtask

  function automatic int delta(input int code, input int size);
    if (code == 1) return size;
    if (code == 2) return -size;
    return 0;
  endfunction

  // compares destination units against source units taken from the bench memory
  task automatic check_dst(input string req, input int word, input int ss, input int ds,
                           input int n);
    int size = word ? 2 : 1;
    int sd = delta(ss, size);
    int dd = delta(ds, size);
    for (int k = 0; k < n; k++) begin
      if (dd == 0 && k != n - 1) continue;
      for (int b = 0; b < size; b++)
        chk(req, mem[8'(DB + k * dd + b)], mem[8'(SB + k * sd + b)]);
    end
    if (dd != 0) chk({req, " beyond"}, mem[8'(DB + n * dd)], 0);
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (irq) break;
      tick(1);
    end
  endtask

  task automatic one_round(input int mode, input int word, input int ss, input int ds,
                           input int n, input bit sw);
    if (mode[0]) begin
      pulse_trig(sw, 2);
      wait_irq(60);
      tick(3);
    end else begin
      for (int k = 0; k < n; k++) begin
        if (k == n - 1) chk("R2 no early irq", irq, 0);
        pulse_trig(sw, 2);
        tick(4);
      end
    end
    chk("R2 R3 irq at completion", irq, 1);
    chk("R4 armed after completion", armed, mode[1]);
    check_dst("R1 R8 data", word, ss, ds, n);
  endtask

  initial begin
    tick(200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst = 1'b1; trig_in = '0; sw_req = 0; arm = 0; disarm = 0; irq_clr = 0;
    set_cfg(0, 0, 1, 1, 3, 0);
    init_mem();
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("reset armed", armed, 0);
    chk("reset irq", irq, 0);
    chk("reset rd_en", mem_rd_en, 0);
    chk("reset wr_en", mem_wr_en, 0);

    // sweep: modes x unit size x source step x destination step
    for (int mode = 0; mode < 4; mode++)
      for (int word = 0; word < 2; word++)
        for (int ss = 0; ss < 3; ss++)
          for (int ds = 0; ds < 3; ds++) begin
            bit sw = 1'((ss + ds + mode) % 2);
            clear_dst();
            set_cfg(mode, word, ss, ds, 3, 0);
            pulse_arm();
            chk("R7 armed", armed, 1);
            one_round(mode, word, ss, ds, 3, sw);
            tick(8);
            chk("R11 irq sticky", irq, 1);
            pulse_clr();
            chk("R11 irq cleared", irq, 0);
            if (mode[1]) begin
              clear_dst();
              one_round(mode, word, ss, ds, 3, !sw);   // R4 pointers reloaded
              pulse_clr();
              pulse_disarm();
              chk("R13 disarmed", armed, 0);
            end else begin
              clear_dst();
              pulse_trig(sw, 2);
              tick(6);
              chk("R6 trigger while disarmed", mem[DB], 0);
              chk("R6 no irq", irq, 0);
            end
          end

    // R3 R12 cycle timing of a block of three bytes
    clear_dst();
    set_cfg(1, 0, 1, 1, 3, 0);
    pulse_arm();
    trig_in[2] = 1'b1;
    tick(1);
    trig_in = '0;
    chk("R12 read 1", mem_rd_en, 1);
    tick(1); chk("R12 gap 1", mem_rd_en, 0);
    tick(1); chk("R3 read 2", mem_rd_en, 1); chk("R12 write 1", mem_wr_en, 1);
    chk("R1 byte upper zero", mem_wr_data[15:8], 0);
    tick(1); chk("R12 gap 2", mem_rd_en, 0);
    tick(1); chk("R3 read 3", mem_rd_en, 1);
    tick(1); chk("R3 irq not yet", irq, 0);
    tick(1); chk("R3 irq on time", irq, 1); chk("R3 disarmed", armed, 0);
    tick(3);
    check_dst("R3 block data", 0, 1, 1, 3);
    pulse_clr();

    // R10 zero count
    clear_dst();
    set_cfg(0, 0, 1, 1, 0, 0);
    pulse_arm();
    pulse_trig(0, 2);
    pulse_trig(1, 2);
    tick(8);
    chk("R10 armed", armed, 1);
    chk("R10 irq", irq, 0);
    chk("R10 no data", mem[DB], 0);
    pulse_disarm();

    // R6 software request while disarmed is dropped; R5 wrong line ignored
    clear_dst();
    set_cfg(0, 0, 1, 1, 3, 0);
    pulse_trig(1, 2);
    pulse_arm();
    tick(8);
    chk("R6 stale sw request", mem[DB], 0);
    pulse_trig(0, 5);
    tick(8);
    chk("R5 unselected line", mem[DB], 0);
    pulse_trig(0, 2);
    tick(6);
    chk("R5 selected line", mem[DB], mem[SB]);
    pulse_trig(1, 0);
    tick(10);
    chk("R5 one sw unit", mem[DB + 1], mem[SB + 1]);
    chk("R5 sw consumed", mem[DB + 2], 0);
    chk("R5 no irq yet", irq, 0);
    pulse_disarm();

    // R9 variable length, block mode, count cap 6
    begin
      int codes [6] = '{2, 3, 1, 4, 2, 2};
      int lens  [6] = '{3, 2, 9, 1, 0, 2};
      int words [6] = '{0, 0, 0, 0, 0, 1};
      int expn  [6] = '{3, 4, 6, 4, 1, 2};
      for (int t = 0; t < 6; t++) begin
        init_mem();
        mem[SB] = 8'(lens[t]);
        if (words[t] != 0) mem[SB + 1] = 8'h00;
        set_cfg(1, words[t], 1, 1, 6, codes[t]);
        pulse_arm();
        pulse_trig(0, 2);
        wait_irq(60);
        tick(3);
        chk("R9 irq", irq, 1);
        check_dst("R9 length", words[t], 1, 1, expn[t]);
        pulse_clr();
      end
    end

    done = 1;
    report();
  end
endmodule